// File: doc/BRIEF.md
# Serial Character Transmitter with Request Arbitration

This block is the sending half of a serial communication port. Software places a byte in a one-entry holding register. On each pulse of an external bit-rate enable the block moves one bit of the current character onto the transmit line. A three-bit code selects the character format. The formats are a plain eight-bit synchronous shift, a ten-bit asynchronous character, an eleven-bit asynchronous character with even or odd parity, and an eleven-bit multidrop character whose ninth bit marks an address.

Two further kinds of character share the line with data. A rising edge of the transmit enable queues a preamble, which is one character-length of idle marks. Raising the break control queues a break, which is one character-length of zeros. The break repeats for as long as the control stays high. The block picks what to send next only when the character in flight has fully finished. The preamble wins over the break, and the break wins over data. Dropping the port enable puts the whole transmit path back into its idle state, while the control inputs themselves are left as they are.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever nothing is being sent, `txd` is 1, `tdre` is 1 and `tx_empty` is 1.
- R2: Format code 3'b000 sends exactly 8 data bits with no start, parity or stop bit.
- R3: Format code 3'b010 sends a 0 start bit, 8 data bits and a 1 stop bit, which is 10 bits in all. The unused codes 3'b001, 3'b011 and 3'b111 send the same 10-bit character.
- R4: Format codes 3'b100 and 3'b101 send 11 bits: a 0 start bit, 8 data bits, a parity bit and a 1 stop bit. With 3'b100 the number of ones in data plus parity is even. With 3'b101 it is odd.
- R5: Format code 3'b110 sends 11 bits: a 0 start bit, 8 data bits, then the value of `addr_bit` as the ninth bit, then a 1 stop bit.
- R6: With `msb_first` = 0 the data bits go out bit 0 first. With `msb_first` = 1 they go out bit 7 first.
- R7: A 0-to-1 change of `tx_en` queues a preamble: a character of the current format's length in which every bit is 1. `tx_empty` is 0 from the clock after the change until the preamble has finished.
- R8: While `brk` is 1, each new character is a break: the current format's length, with every bit 0. A `brk` pulse shorter than a character still queues exactly one break.
- R9: A character in flight is never cut short. At the tick after its last bit, a queued preamble is taken first, then a break, then data.
- R10: Data is sent only when `tdre` is 0 and `tx_en` is 1. A write clears `tdre` on the next clock. `tdre` returns to 1 at the tick that starts that byte, and a byte written during a character follows it with no idle bit in between.
- R11: `port_en` = 0 drives `txd` to 1 and `tdre` to 1 on the next clock and discards queued requests. Writes, `tx_en` edges and `brk` pulses seen while `port_en` is 0 have no effect once the port is enabled again.
- R12: `tx_empty` is 1 only when no character is in flight, `tdre` is 1, no preamble or break is queued and `brk` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Port pin-function enable; 0 holds the transmitter idle |
| bit_tick | input | 1 | One-clock enable marking each bit period |
| tx_en | input | 1 | Transmit enable; a rising edge queues a preamble |
| brk | input | 1 | Break control |
| fmt | input | 3 | Character format code |
| msb_first | input | 1 | Data bit order select |
| addr_bit | input | 1 | Ninth bit for multidrop characters |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial transmit line |
| tdre | output | 1 | Holding register empty |
| tx_empty | output | 1 | Transmitter fully idle |

## Verification
Control inputs are registered one clock after they change. So `tdre` falls, and `tx_empty` reflects a new request, at the first rising edge after the stimulus. The first bit of a character appears on `txd` at the rising edge of the first `bit_tick` after the request was registered. Each later bit appears one tick further on. `port_en` = 0 takes effect on the very next edge.

The bench never pulses `bit_tick` in the same cycle as a write or a control change. It samples `txd` and the flags on the falling edge after each tick's rising edge. It compares the whole captured bit stream against a stream that bench functions build from the format rules.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_PRE  = 2'd1,
    K_BRK  = 2'd2,
    K_DAT  = 2'd3
  } kind_e;

  localparam logic [2:0] FMT_SYNC  = 3'b000;
  localparam logic [2:0] FMT_EVEN  = 3'b100;
  localparam logic [2:0] FMT_ODD   = 3'b101;
  localparam logic [2:0] FMT_MDROP = 3'b110;
endpackage

// File: rtl/sertx_req.sv
module sertx_req import sertx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              brk,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              boundary,
  output kind_e             sel,
  output logic [DATA_W-1:0] hold,
  output logic              tdre,
  output logic              req_pend
);
  logic tx_en_d, brk_d, pre_pend, brk_pend;
  logic pre_set, brk_set;
  logic take_pre, take_brk, take_dat;

  assign pre_set = tx_en & ~tx_en_d;
  assign brk_set = brk & ~brk_d;

  always_comb begin
    if (pre_pend)                sel = K_PRE;
    else if (brk_pend || brk)    sel = K_BRK;
    else if (!tdre && tx_en)     sel = K_DAT;
    else                         sel = K_NONE;
  end

  assign take_pre = boundary && (sel == K_PRE);
  assign take_brk = boundary && (sel == K_BRK);
  assign take_dat = boundary && (sel == K_DAT);
  assign req_pend = pre_pend | brk_pend | brk;

  // edge trackers follow the inputs even while the port is off
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_d <= 1'b0;
      brk_d   <= 1'b0;
    end else begin
      tx_en_d <= tx_en;
      brk_d   <= brk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      pre_pend <= 1'b0;
      brk_pend <= 1'b0;
      tdre     <= 1'b1;
      hold     <= '0;
    end else begin
      if (pre_set)       pre_pend <= 1'b1;
      else if (take_pre) pre_pend <= 1'b0;
      if (brk_set)       brk_pend <= 1'b1;
      else if (take_brk) brk_pend <= 1'b0;
      if (wr_valid) begin
        hold <= wr_data;
        tdre <= 1'b0;
      end else if (take_dat) begin
        tdre <= 1'b1;
      end
    end
  end

  p_tdre_after_take_r10: assert property (@(posedge clk) disable iff (rst)
    (take_dat && !wr_valid && port_en) |=> tdre);
  p_portoff_clears_r11: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (tdre && !pre_pend && !brk_pend));
  p_pre_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (take_pre && !pre_set && port_en) |=> !pre_pend);
  p_brk_level_r8: assert property (@(posedge clk) disable iff (rst)
    (boundary && brk && !pre_pend) |-> take_brk);
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame import sertx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  kind_e                         kind,
  input  logic [2:0]                    fmt,
  input  logic                          msb_first,
  input  logic                          addr_bit,
  input  logic [DATA_W-1:0]             data,
  output logic [DATA_W+2:0]             frame,
  output logic [$clog2(DATA_W+4)-1:0]   len
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_SYNC  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DATA_W + 3);

  logic [DATA_W-1:0] rev, ordered;
  logic              par;
  logic [FRAME_W-1:0] body;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = data[DATA_W-1-i];
  end

  assign ordered = msb_first ? rev : data;
  assign par     = ^data;

  always_comb begin
    case (fmt)
      FMT_SYNC: begin
        body = {3'b111, ordered};
        len  = LEN_SYNC;
      end
      FMT_EVEN: begin
        body = {1'b1, par, ordered, 1'b0};
        len  = LEN_LONG;
      end
      FMT_ODD: begin
        body = {1'b1, ~par, ordered, 1'b0};
        len  = LEN_LONG;
      end
      FMT_MDROP: begin
        body = {1'b1, addr_bit, ordered, 1'b0};
        len  = LEN_LONG;
      end
      default: begin
        body = {2'b11, ordered, 1'b0};
        len  = LEN_SHORT;
      end
    endcase
    case (kind)
      K_PRE:   frame = '1;
      K_BRK:   frame = '0;
      K_DAT:   frame = body;
      default: frame = '1;
    endcase
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift import sertx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        port_en,
  input  logic                        bit_tick,
  input  kind_e                       sel,
  input  logic [DATA_W+2:0]           frame,
  input  logic [$clog2(DATA_W+4)-1:0] len,
  output logic                        txd,
  output logic                        active,
  output logic                        boundary
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  // a boundary is the tick after the last bit of a character, or any idle tick
  assign boundary = port_en && bit_tick && (!active || cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '1;
      txd    <= 1'b1;
    end else if (boundary) begin
      if (sel != K_NONE) begin
        txd    <= frame[0];
        sh     <= {1'b1, frame[FRAME_W-1:1]};
        cnt    <= len - 1'b1;
        active <= 1'b1;
      end else begin
        txd    <= 1'b1;
        active <= 1'b0;
      end
    end else if (bit_tick && active) begin
      txd <= sh[0];
      sh  <= {1'b1, sh[FRAME_W-1:1]};
      cnt <= cnt - 1'b1;
    end
  end

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    !active |-> txd);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < CNT_W'(FRAME_W)));
  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (rst)
    (port_en && !bit_tick) |=> $stable(txd));
endmodule

// File: rtl/sertx_top.sv
module sertx_top import sertx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              brk,
  input  logic [2:0]        fmt,
  input  logic              msb_first,
  input  logic              addr_bit,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tdre,
  output logic              tx_empty
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  kind_e              sel;
  logic [DATA_W-1:0]  hold;
  logic               req_pend, boundary, active;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;

  sertx_req #(.DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .port_en(port_en), .tx_en(tx_en), .brk(brk),
    .wr_valid(wr_valid), .wr_data(wr_data), .boundary(boundary),
    .sel(sel), .hold(hold), .tdre(tdre), .req_pend(req_pend)
  );

  sertx_frame #(.DATA_W(DATA_W)) u_frame (
    .kind(sel), .fmt(fmt), .msb_first(msb_first), .addr_bit(addr_bit),
    .data(hold), .frame(frame), .len(len)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .port_en(port_en), .bit_tick(bit_tick),
    .sel(sel), .frame(frame), .len(len),
    .txd(txd), .active(active), .boundary(boundary)
  );

  assign tx_empty = !active && tdre && !req_pend;

  p_empty_line_r12: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);
endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
  logic clk = 0, rst = 1, port_en = 0, bit_tick = 0, tx_en = 0, brk = 0;
  logic msb_first = 0, addr_bit = 0, wr_valid = 0;
  logic [2:0] fmt = 3'b010;
  logic [7:0] wr_data = 8'h00;
  logic txd, tdre, tx_empty;
  int checks = 0, errors = 0;
  bit done = 0;
  logic got [0:63];
  logic expv [0:63];
  int gp = 0, ep = 0;

  sertx_top u0 (
    .clk(clk), .rst(rst), .port_en(port_en), .bit_tick(bit_tick), .tx_en(tx_en),
    .brk(brk), .fmt(fmt), .msb_first(msb_first), .addr_bit(addr_bit),
    .wr_valid(wr_valid), .wr_data(wr_data), .txd(txd), .tdre(tdre), .tx_empty(tx_empty)
  );

  always #10 clk = ~clk;

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      got[gp] = txd;
      gp++;
    end
  endtask

  task automatic clear();
    gp = 0;
    ep = 0;
  endtask

  task automatic push(input logic b);
    expv[ep] = b;
    ep++;
  endtask

  task automatic push_const(input logic b, input int n);
    for (int i = 0; i < n; i++) push(b);
  endtask

  function automatic int flen(input logic [2:0] f);
    if (f == 3'b000) return 8;
    if (f == 3'b100 || f == 3'b101 || f == 3'b110) return 11;
    return 10;
  endfunction

  task automatic push_frame(input logic [2:0] f, input logic m, input logic a, input logic [7:0] d);
    int ones;
    ones = $countones(d);
    if (f != 3'b000) push(1'b0);
    for (int i = 0; i < 8; i++) push(m ? d[7-i] : d[i]);
    if (f == 3'b100) push(ones % 2 == 1);
    if (f == 3'b101) push(ones % 2 == 0);
    if (f == 3'b110) push(a);
    if (f != 3'b000) push(1'b1);
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    checks++;
    for (int i = 0; i < ep; i++)
      if (bad < 0 && (i >= gp || got[i] !== expv[i])) bad = i;
    if (gp != ep || bad >= 0) begin
      errors++;
      if (bad >= 0)
        $display("FAIL %s: bit %0d got %0b expected %0b (bits %0d/%0d)", tag, bad,
                 (bad < gp) ? got[bad] : 1'bx, expv[bad], gp, ep);
      else
        $display("FAIL %s: got %0d bits expected %0d", tag, gp, ep);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk) begin wr_valid = 1; wr_data = d; end
    @(negedge clk) wr_valid = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    string tag;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    port_en = 1;
    @(negedge clk);
    check1("R1 txd idle", txd, 1'b1);
    check1("R1 tdre", tdre, 1'b1);
    check1("R1 tx_empty", tx_empty, 1'b1);

    // R7: preamble alone
    fmt = 3'b010;
    @(negedge clk) tx_en = 1;
    @(negedge clk);
    check1("R7 tx_empty low while queued", tx_empty, 1'b0);
    clear(); run(10); push_const(1'b1, 10); compare("R7 preamble marks");
    check1("R7 tx_empty low during preamble", tx_empty, 1'b0);
    tick();
    check1("R12 empty after preamble", tx_empty, 1'b1);

    // R2..R6: random characters
    for (int k = 0; k < 40; k++) begin
      fmt = 3'($urandom_range(0, 7));
      msb_first = 1'($urandom);
      addr_bit = 1'($urandom);
      d = 8'($urandom);
      if (k == 0) begin fmt = 3'b000; msb_first = 1; d = 8'h81; end
      if (k == 1) begin fmt = 3'b101; d = 8'h00; end
      if (k == 2) begin fmt = 3'b110; addr_bit = 1; d = 8'hFF; end
      write_byte(d);
      check1("R10 tdre cleared by write", tdre, 1'b0);
      clear();
      run(1);
      check1("R10 tdre set at load", tdre, 1'b1);
      run(flen(fmt) - 1);
      push_frame(fmt, msb_first, addr_bit, d);
      if (fmt == 3'b000) tag = "R2";
      else if (fmt == 3'b100 || fmt == 3'b101) tag = "R4";
      else if (fmt == 3'b110) tag = "R5";
      else tag = "R3";
      compare($sformatf("%s R6 fmt=%0d msb=%0b data=%02h", tag, fmt, msb_first, d));
      tick();
      check1("R1 line idle after char", txd, 1'b1);
      check1("R12 empty after char", tx_empty, 1'b1);
    end

    // R10: back to back
    fmt = 3'b100; msb_first = 0;
    d = 8'hA5; d2 = 8'h3C;
    write_byte(d);
    clear(); run(1);
    write_byte(d2);
    run(10 + 11);
    push_frame(3'b100, 1'b0, 1'b0, d); push_frame(3'b100, 1'b0, 1'b0, d2);
    compare("R10 back to back");
    tick();
    check1("R12 empty after pair", tx_empty, 1'b1);

    // R10 gating by tx_en, then R9 preamble ahead of data
    fmt = 3'b010;
    @(negedge clk) tx_en = 0;
    d = 8'h5B;
    write_byte(d);
    clear(); run(12); push_const(1'b1, 12); compare("R10 no data while tx_en low");
    check1("R10 tdre held while gated", tdre, 1'b0);
    @(negedge clk) tx_en = 1;
    clear(); run(20);
    push_const(1'b1, 10); push_frame(3'b010, 1'b0, 1'b0, d);
    compare("R9 preamble before data");
    tick();

    // R8/R9 break ahead of data, repeating while brk high
    d = 8'hC3;
    @(negedge clk) begin brk = 1; wr_valid = 1; wr_data = d; end
    @(negedge clk) wr_valid = 0;
    clear(); run(15);
    @(negedge clk) brk = 0;
    run(5); run(10);
    push_const(1'b0, 20); push_frame(3'b010, 1'b0, 1'b0, d);
    compare("R8 R9 break repeats then data");
    tick();
    check1("R12 empty after break", tx_empty, 1'b1);

    // R9 preamble ahead of break
    @(negedge clk) tx_en = 0;
    @(negedge clk) begin tx_en = 1; brk = 1; end
    @(negedge clk);
    check1("R12 not empty with brk", tx_empty, 1'b0);
    clear(); run(13);
    @(negedge clk) brk = 0;
    run(7); run(2);
    push_const(1'b1, 10); push_const(1'b0, 10); push_const(1'b1, 2);
    compare("R9 preamble before break");
    check1("R12 empty after preamble+break", tx_empty, 1'b1);

    // R8 short pulse latched during a character
    fmt = 3'b101; msb_first = 1; d = 8'h96;
    write_byte(d);
    clear(); run(3);
    @(negedge clk) brk = 1;
    @(negedge clk) brk = 0;
    run(8); run(11); run(2);
    push_frame(3'b101, 1'b1, 1'b0, d); push_const(1'b0, 11); push_const(1'b1, 2);
    compare("R8 latched single break");

    // R11 port disable
    fmt = 3'b010; msb_first = 0; d = 8'h00;
    write_byte(d);
    clear(); run(1); push(1'b0); compare("R11 start bit before disable");
    @(negedge clk) port_en = 0;
    @(negedge clk);
    check1("R11 txd idle after disable", txd, 1'b1);
    check1("R11 tdre after disable", tdre, 1'b1);
    write_byte(8'h11);
    @(negedge clk) tx_en = 0;
    @(negedge clk) begin tx_en = 1; brk = 1; end
    @(negedge clk) brk = 0;
    @(negedge clk) port_en = 1;
    @(negedge clk);
    check1("R11 write ignored while off", tdre, 1'b1);
    check1("R11 no request kept", tx_empty, 1'b1);
    clear(); run(12); push_const(1'b1, 12); compare("R11 line idle after re-enable");
    d = 8'h6E;
    write_byte(d);
    clear(); run(10); push_frame(3'b010, 1'b0, 1'b0, d); compare("R11 resumes after re-enable");
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule